// File: doc/BRIEF.md
# Tagged Self-Description Stream Transmitter

This block answers a query by sending a fixed self-description of the capture device as a stream of bytes over a byte-wide valid/ready output. The stream is a series of tagged records. Each record opens with a key byte. The three most significant bits of the key choose how the payload that follows is laid out, and the low bits say which quantity the record carries. A lone zero key closes the stream. The device name and the firmware version are text parameters of the block. The channel count, the sample memory size, the top sample rate and the protocol version arrive on input ports, and the block captures them when the stream starts.

A command decoder drives `start` for one cycle when the host asks for the description. A serial transmitter drains `tx_data` under `tx_valid`/`tx_ready`. Neither of those is part of this block.

The control is a four-state machine:
- IDLE: no output.
- KEY: presents the key byte of the current record.
- BODY: walks the payload bytes of the current record.
- STOP: presents the closing zero key.

The transitions are:
- GO (IDLE to KEY): on `start`.
- KEY_SENT (KEY to BODY): on a transfer.
- NEXT_REC (BODY to KEY): when the last payload byte of a record that is not the final record is transferred.
- LAST_REC (BODY to STOP): when the last payload byte of the final record is transferred.
- DONE (STOP to IDLE): when the zero key is transferred.

Every other case holds the current state. A transfer is a cycle with `tx_valid` and `tx_ready` both high.

Top module: `devinfo_tx`

## Requirements
- R1: While reset is applied and after it is released, `tx_valid` and `busy` are low until `start` is seen.
- R2: A `start` sampled high in IDLE makes `tx_valid` and `busy` high in the next cycle, with the first key byte on `tx_data`.
- R3: Records go out in a fixed order, each identified by its key byte: name 0x01, firmware version 0x02, channel count 0x40, sample memory bytes 0x21, top sample rate in Hz 0x23, protocol version 0x41.
- R4: Bits 7:5 of every key give the payload format: 0 is NUL-ended text, 1 is a 32-bit unsigned value, 2 is one unsigned byte.
- R5: A text payload sends its characters first to last, then one 0x00 byte. With the default parameters the name is "LA32" and the version is "3.1".
- R6: A 32-bit payload goes out as four bytes, most significant byte first.
- R7: A one-byte payload goes out as exactly one byte.
- R8: After the last record, one 0x00 key byte is sent. Once it is transferred, `busy` and `tx_valid` are low in the next cycle. With the defaults the stream is 26 bytes long.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold their values into the next cycle. No byte is dropped or repeated.
- R10: A `start` that arrives while a stream is in progress has no effect. The stream is unchanged, and no second stream follows it.
- R11: The numeric inputs are captured in the cycle `start` is accepted. Changing them during a stream does not change the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Query pulse that begins a stream |
| busy | output | 1 | High from the first key until the closing key is transferred |
| chan_count | input | 8 | Number of usable channels |
| mem_bytes | input | 32 | Sample memory size in bytes |
| max_rate | input | 32 | Top sample rate in Hz |
| proto_ver | input | 8 | Protocol version |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte present |
| tx_ready | input | 1 | Receiver accepts the byte this cycle |

## Verification
The first key byte is due in the cycle after the edge that samples `start`. After that, each new byte is due in the cycle after the edge that completes a transfer, and the data and valid outputs come straight from the state registers with no added register stage. The bench drives `start`, `tx_ready` and the numeric inputs on the falling edge. On that same falling edge it reads `tx_data` and `tx_valid`, so every value it checks was settled by the preceding rising edge. Stalls use several `tx_ready` patterns. Each stalled cycle is compared with the byte seen one cycle earlier, and each transfer is compared with a byte list that the bench builds from the key and format rules.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

    typedef enum logic [2:0] {
        FMT_TEXT = 3'd0,
        FMT_WORD = 3'd1,
        FMT_BYTE = 3'd2
    } fmt_e;

    typedef enum logic [2:0] {
        REC_NAME,
        REC_FW,
        REC_CHANS,
        REC_MEM,
        REC_RATE,
        REC_PROTO
    } rec_e;

    localparam logic [7:0] KEY_NAME  = 8'h01;
    localparam logic [7:0] KEY_FW    = 8'h02;
    localparam logic [7:0] KEY_CHANS = 8'h40;
    localparam logic [7:0] KEY_MEM   = 8'h21;
    localparam logic [7:0] KEY_RATE  = 8'h23;
    localparam logic [7:0] KEY_PROTO = 8'h41;
    localparam logic [7:0] KEY_STOP  = 8'h00;

    localparam rec_e REC_FINAL = REC_PROTO;

endpackage

// File: rtl/dtx_rec_table.sv
module dtx_rec_table
    import dtx_pkg::*;
#(
    parameter int NAME_CHARS = 4,
    parameter int FW_CHARS   = 3,
    parameter int POS_W      = 3
) (
    input  rec_e             rec,
    output logic [7:0]       key,
    output fmt_e             fmt,
    output logic [POS_W-1:0] last_pos
);

    always_comb begin
        unique case (rec)
            REC_NAME: begin
                key      = KEY_NAME;
                fmt      = FMT_TEXT;
                last_pos = POS_W'(NAME_CHARS);
            end
            REC_FW: begin
                key      = KEY_FW;
                fmt      = FMT_TEXT;
                last_pos = POS_W'(FW_CHARS);
            end
            REC_CHANS: begin
                key      = KEY_CHANS;
                fmt      = FMT_BYTE;
                last_pos = '0;
            end
            REC_MEM: begin
                key      = KEY_MEM;
                fmt      = FMT_WORD;
                last_pos = POS_W'(3);
            end
            REC_RATE: begin
                key      = KEY_RATE;
                fmt      = FMT_WORD;
                last_pos = POS_W'(3);
            end
            REC_PROTO: begin
                key      = KEY_PROTO;
                fmt      = FMT_BYTE;
                last_pos = '0;
            end
            default: begin
                key      = KEY_STOP;
                fmt      = FMT_BYTE;
                last_pos = '0;
            end
        endcase
    end

endmodule

// File: rtl/dtx_payload.sv
module dtx_payload
    import dtx_pkg::*;
#(
    parameter int                      NAME_CHARS = 4,
    parameter logic [8*NAME_CHARS-1:0] NAME_TEXT  = "LA32",
    parameter int                      FW_CHARS   = 3,
    parameter logic [8*FW_CHARS-1:0]   FW_TEXT    = "3.1",
    parameter int                      POS_W      = 3
) (
    input  rec_e             rec,
    input  logic [POS_W-1:0] pos,
    input  logic [7:0]       chans,
    input  logic [31:0]      mem,
    input  logic [31:0]      rate,
    input  logic [7:0]       proto,
    output logic [7:0]       body_byte
);

    logic [7:0] name_b [NAME_CHARS+1];
    logic [7:0] fw_b   [FW_CHARS+1];
    logic [7:0] name_sel, fw_sel, mem_sel, rate_sel;

    // Text payloads: first character at the top of the parameter, NUL last
    for (genvar g = 0; g < NAME_CHARS; g++) begin : g_name
        assign name_b[g] = NAME_TEXT[8*(NAME_CHARS-1-g) +: 8];
    end
    assign name_b[NAME_CHARS] = 8'h00;

    for (genvar g = 0; g < FW_CHARS; g++) begin : g_fw
        assign fw_b[g] = FW_TEXT[8*(FW_CHARS-1-g) +: 8];
    end
    assign fw_b[FW_CHARS] = 8'h00;

    always_comb begin
        name_sel = 8'h00;
        for (int i = 0; i <= NAME_CHARS; i++)
            if (pos == POS_W'(i)) name_sel = name_b[i];
        fw_sel = 8'h00;
        for (int i = 0; i <= FW_CHARS; i++)
            if (pos == POS_W'(i)) fw_sel = fw_b[i];
    end

    // Word payloads leave most significant byte first
    always_comb begin
        case (int'(pos))
            0:       begin mem_sel = mem[31:24]; rate_sel = rate[31:24]; end
            1:       begin mem_sel = mem[23:16]; rate_sel = rate[23:16]; end
            2:       begin mem_sel = mem[15:8];  rate_sel = rate[15:8];  end
            default: begin mem_sel = mem[7:0];   rate_sel = rate[7:0];   end
        endcase
    end

    always_comb begin
        unique case (rec)
            REC_NAME:  body_byte = name_sel;
            REC_FW:    body_byte = fw_sel;
            REC_CHANS: body_byte = chans;
            REC_MEM:   body_byte = mem_sel;
            REC_RATE:  body_byte = rate_sel;
            REC_PROTO: body_byte = proto;
            default:   body_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/devinfo_tx.sv
module devinfo_tx
    import dtx_pkg::*;
#(
    parameter int                      NAME_CHARS = 4,
    parameter logic [8*NAME_CHARS-1:0] NAME_TEXT  = "LA32",
    parameter int                      FW_CHARS   = 3,
    parameter logic [8*FW_CHARS-1:0]   FW_TEXT    = "3.1"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    input  logic [7:0]  chan_count,
    input  logic [31:0] mem_bytes,
    input  logic [31:0] max_rate,
    input  logic [7:0]  proto_ver,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready
);

    localparam int MAX_CHARS = (NAME_CHARS > FW_CHARS) ? NAME_CHARS : FW_CHARS;
    localparam int MAX_BODY  = (MAX_CHARS + 1 > 4) ? MAX_CHARS + 1 : 4;
    localparam int POS_W     = $clog2(MAX_BODY);

    typedef enum logic [1:0] {ST_IDLE, ST_KEY, ST_BODY, ST_STOP} state_e;

    state_e           state, state_nxt;
    rec_e             rec, rec_nxt;
    logic [POS_W-1:0] pos, pos_nxt;
    logic [7:0]       cap_chans, cap_proto;
    logic [31:0]      cap_mem, cap_rate;
    logic             accept;

    logic [7:0]       key_w, body_w;
    fmt_e             fmt_w;
    logic [POS_W-1:0] last_pos;
    logic             fire;

    dtx_rec_table #(
        .NAME_CHARS (NAME_CHARS),
        .FW_CHARS   (FW_CHARS),
        .POS_W      (POS_W)
    ) u_table (
        .rec      (rec),
        .key      (key_w),
        .fmt      (fmt_w),
        .last_pos (last_pos)
    );

    dtx_payload #(
        .NAME_CHARS (NAME_CHARS),
        .NAME_TEXT  (NAME_TEXT),
        .FW_CHARS   (FW_CHARS),
        .FW_TEXT    (FW_TEXT),
        .POS_W      (POS_W)
    ) u_payload (
        .rec       (rec),
        .pos       (pos),
        .chans     (cap_chans),
        .mem       (cap_mem),
        .rate      (cap_rate),
        .proto     (cap_proto),
        .body_byte (body_w)
    );

    assign fire = tx_valid && tx_ready;

    // State register and captured values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rec       <= REC_NAME;
            pos       <= '0;
            cap_chans <= '0;
            cap_mem   <= '0;
            cap_rate  <= '0;
            cap_proto <= '0;
        end else begin
            state <= state_nxt;
            rec   <= rec_nxt;
            pos   <= pos_nxt;
            if (accept) begin
                cap_chans <= chan_count;
                cap_mem   <= mem_bytes;
                cap_rate  <= max_rate;
                cap_proto <= proto_ver;
            end
        end
    end

    // Transitions: GO, KEY_SENT, NEXT_REC, LAST_REC, DONE
    always_comb begin
        state_nxt = state;
        rec_nxt   = rec;
        pos_nxt   = pos;
        accept    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    state_nxt = ST_KEY;
                    rec_nxt   = REC_NAME;
                    pos_nxt   = '0;
                end
            end
            ST_KEY: begin
                if (fire) begin
                    state_nxt = ST_BODY;
                    pos_nxt   = '0;
                end
            end
            ST_BODY: begin
                if (fire) begin
                    if (pos == last_pos) begin
                        pos_nxt = '0;
                        if (rec == REC_FINAL) begin
                            state_nxt = ST_STOP;
                        end else begin
                            state_nxt = ST_KEY;
                            rec_nxt   = rec_e'(rec + 3'd1);
                        end
                    end else begin
                        pos_nxt = pos + POS_W'(1);
                    end
                end
            end
            ST_STOP: begin
                if (fire) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b1;
        busy     = 1'b1;
        tx_data  = KEY_STOP;
        unique case (state)
            ST_IDLE: begin
                tx_valid = 1'b0;
                busy     = 1'b0;
            end
            ST_KEY:  tx_data = key_w;
            ST_BODY: tx_data = body_w;
            ST_STOP: tx_data = KEY_STOP;
            default: begin
                tx_valid = 1'b0;
                busy     = 1'b0;
            end
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tx_valid); // R1

    AST_KEY_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEY) |-> (tx_data[7:5] == fmt_w)); // R4

    AST_BODY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> (pos <= last_pos)); // R5

    AST_STOP_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && fire) |=> !busy && !tx_valid); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(state == ST_STOP && fire)) |=> busy); // R10

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_STOP) |=> $stable(cap_mem) && $stable(cap_rate)); // R11

endmodule

// File: tb/devinfo_tx_test.sv
`timescale 1ns/1ps
module devinfo_tx_test;

    localparam int STREAM_LEN = 26;
    localparam int NVEC = 4;
    // {ready mode, channel count, memory bytes, top rate, protocol version}
    localparam logic [81:0] VECS [NVEC] = '{
        {2'd0, 8'd32,  32'h0006_0000, 32'h05F5_E100, 8'd2},
        {2'd1, 8'h81,  32'hA1B2_C3D4, 32'h0102_0304, 8'hFF},
        {2'd2, 8'd0,   32'hFFFF_FFFF, 32'h0000_0000, 8'h00},
        {2'd3, 8'hFE,  32'h8000_0001, 32'h7F00_FF80, 8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy;
    logic [7:0]  chan_count = '0;
    logic [31:0] mem_bytes = '0;
    logic [31:0] max_rate = '0;
    logic [7:0]  proto_ver = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    devinfo_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .chan_count (chan_count),
        .mem_bytes  (mem_bytes),
        .max_rate   (max_rate),
        .proto_ver  (proto_ver),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [7:0] c, input logic [31:0] m,
                                            input logic [31:0] r, input logic [7:0] p);
        case (i)
            0: return 8'h01;  1: return "L"; 2: return "A"; 3: return "3"; 4: return "2"; 5: return 8'h00;
            6: return 8'h02;  7: return "3"; 8: return "."; 9: return "1"; 10: return 8'h00;
            11: return 8'h40; 12: return c;
            13: return 8'h21; 14: return m[31:24]; 15: return m[23:16]; 16: return m[15:8]; 17: return m[7:0];
            18: return 8'h23; 19: return r[31:24]; 20: return r[23:16]; 21: return r[15:8]; 22: return r[7:0];
            23: return 8'h41; 24: return p;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        if (i == 0 || i == 6 || i == 11 || i == 13 || i == 18 || i == 23) return "R3 key";
        if (i <= 10) return "R5 text";
        if (i == 12 || i == 24) return "R7 byte";
        if (i == STREAM_LEN - 1) return "R8 stop key";
        return "R6 word";
    endfunction

    function automatic logic [2:0] fmt_of(input int i);
        if (i == 0 || i == 6) return 3'd0;
        if (i == 13 || i == 18) return 3'd1;
        return 3'd2;
    endfunction

    function automatic bit ready_of(input int mode, input int k);
        case (mode)
            0: return 1'b1;
            1: return (k % 2) == 1;
            2: return (k % 3) == 2;
            default: return (k >= 4) && ((k % 5) != 0);
        endcase
    endfunction

    // One full stream; inputs already applied by caller
    task automatic run_stream(input int mode, input bit extra_start, input bit change_inputs);
        logic [7:0]  c = chan_count;
        logic [31:0] m = mem_bytes;
        logic [31:0] r = max_rate;
        logic [7:0]  p = proto_ver;
        int idx = 0;
        int k = 0;
        bit prev_stall = 1'b0;
        logic [7:0] prev_data = '0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(tx_valid && busy, "R2 valid/busy after start", {30'd0, tx_valid, busy}, 32'h3);
        while (idx < STREAM_LEN && k < 2000) begin
            if (prev_stall)
                check(tx_valid && tx_data == prev_data, "R9 hold under stall", {23'd0, tx_valid, tx_data},
                      {23'd1, prev_data});
            tx_ready = ready_of(mode, k);
            if (extra_start && k == 3) start = 1'b1;
            if (extra_start && k == 4) start = 1'b0;
            if (change_inputs && k == 2) begin
                chan_count = ~c; mem_bytes = ~m; max_rate = ~r; proto_ver = ~p;
            end
            if (tx_valid && tx_ready) begin
                check(tx_data == exp_byte(idx, c, m, r, p), tag_of(idx), tx_data, exp_byte(idx, c, m, r, p));
                if (tag_of(idx) == "R3 key")
                    check(tx_data[7:5] == fmt_of(idx), "R4 key format", tx_data[7:5], fmt_of(idx));
                idx++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data = tx_data;
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        tx_ready = 1'b0;
        check(idx == STREAM_LEN, "R8 stream length", idx, STREAM_LEN);
        check(!busy && !tx_valid, "R8 idle after stop key", {30'd0, busy, tx_valid}, 32'h0);
        for (int w = 0; w < 6; w++) begin
            tx_ready = 1'b1;
            @(negedge clk);
            if (extra_start)
                check(!tx_valid, "R10 no second stream", tx_valid, 0);
        end
        tx_ready = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(!tx_valid && !busy, "R1 during reset", {30'd0, tx_valid, busy}, 32'h0);
        start = 1'b0;
        rst_n = 1'b1;
        tx_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(!tx_valid && !busy, "R1 idle after reset", {30'd0, tx_valid, busy}, 32'h0);
        tx_ready = 1'b0;

        // Vector table: several inputs and ready patterns (R2-R9)
        for (int v = 0; v < NVEC; v++) begin
            chan_count = VECS[v][79:72];
            mem_bytes  = VECS[v][71:40];
            max_rate   = VECS[v][39:8];
            proto_ver  = VECS[v][7:0];
            run_stream(int'(VECS[v][81:80]), 1'b0, 1'b0);
        end

        // R10: start during a stream is ignored
        chan_count = 8'h11; mem_bytes = 32'h2233_4455; max_rate = 32'h6677_8899; proto_ver = 8'h03;
        run_stream(1, 1'b1, 1'b0);

        // R11: inputs changed mid-stream do not alter the bytes
        chan_count = 8'h24; mem_bytes = 32'h0F0E_0D0C; max_rate = 32'hC0DE_0001; proto_ver = 8'h07;
        run_stream(2, 1'b0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule